// File: doc/BRIEF.md
# Security Lookup Configuration Register Bank

This block is the software-facing configuration store for a memory-region security gate. The protected region is split into equal blocks. Each block has one bit in a lookup table. A bit of 0 marks the block as reachable only by secure transactions, and a bit of 1 marks it as reachable only by non-secure ones. Software reaches the table one 32-bit word at a time. It sets a word index and then reads or writes a single window register. An optional auto-advance mode lets the index walk the whole table with back-to-back full-word accesses.

The bank also holds a control word with an error-response enable and a lockdown bit. Once lockdown is set, the configuration is frozen until reset. The bank also carries an interrupt status, an enable, and set and clear strobes. The filter next to it reports a blocked transaction on a capture port, and the bank records the offending address and a side-information word. The full table, the control bits and the interrupt line are driven out continuously.

Every register access carries a security attribute. Non-secure accesses can see only the identification area. Elsewhere they read zero and write nothing.

Top module: `sec_lut_regbank`

## Requirements
- R1: A non-secure access (`bus_secure`=0) to any offset below 0xFD0 returns zero on a read and changes nothing on a write. The identification words at 0xFD0 + 4k (k = 0..11) read 0xA0 + k in both worlds.
- R2: After reset:
  - the control word (offset 0x00) reads 0x00000100;
  - the enable (0x28) reads 1;
  - the index (0x18), the status (0x20), the address capture (0x2C) and the info capture (0x30) read 0;
  - every table word is 0;
  - `irq` is 0.
- R3: Offset 0x10 reads the table word count minus one, where the count is ceil(NUM_BLOCKS/32). Offset 0x14 reads log2(BLOCK_BYTES) minus 5.
- R4: A read or write of the window at 0x1C reaches the table word selected by the current index. Table word k is visible at `lut_bits[32k+31:32k]`.
- R5: While control bit 6 is set, a full-word access (`bus_size`=2) to the window advances the index by one, and the index wraps from the last word to 0. Both reads and accepted writes advance it. An access of any other size leaves the index unchanged.
- R6: A write to the index register stores the written value modulo the table word count.
- R7: Only control bits 4, 6 and 31 are writable, and every other control bit keeps its value. `err_resp_en` mirrors bit 4 and `lockdown` mirrors bit 31.
- R8: While `lockdown` is 1:
  - writes to the control, index and window registers are dropped;
  - a dropped window write does not advance the index;
  - only reset clears the lockdown.
- R9: Status and enable behaviour:
  - a write to 0x24 clears the status;
  - a write to 0x34 sets the status;
  - a write to 0x28 keeps only bit 0 as the enable;
  - 0x24 and 0x34 read zero.
- R10: `irq` is 1 exactly when the status and the enable are both 1.
- R11: A `cap_valid` pulse while the status is 0 loads `cap_addr` into 0x2C and `cap_info` into 0x30, and it sets the status. A pulse while the status is 1 leaves both capture registers unchanged.
- R12: When a capture pulse and a clear write fall in the same cycle, the status ends at 1 and the capture registers take the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_secure | input | 1 | Security attribute of the access (1 = secure) |
| bus_size | input | 2 | Access size code, 2 = full 32-bit word |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| cap_valid | input | 1 | Filter reports a blocked transaction |
| cap_addr | input | 32 | Address of the blocked transaction |
| cap_info | input | 32 | Side information packed by the filter |
| lut_bits | output | 32*ceil(NUM_BLOCKS/32) | Whole lookup table, word k in bits [32k+31:32k] |
| err_resp_en | output | 1 | Control bit 4, error response for blocked accesses |
| lockdown | output | 1 | Control bit 31, configuration frozen |
| irq | output | 1 | Interrupt request |

## Verification
The filter's capture pulse and a software write to the status clear or set register can land in the same cycle. If that case is handled wrongly, a blocked transaction is lost. The bench provokes this by setting the status first, then issuing a clear write together with a capture carrying a fresh address. The status must then still read 1 and the address capture must hold the new value. The bench also checks the index advance against a lockdown-dropped window write. It compares every cycle against a behavioural model that applies its own ordering rules.

// File: rtl/sec_lut_pkg.sv
package sec_lut_pkg;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_MAX   = 12'h010;
  localparam logic [11:0] OFS_CFG   = 12'h014;
  localparam logic [11:0] OFS_IDX   = 12'h018;
  localparam logic [11:0] OFS_LUT   = 12'h01C;
  localparam logic [11:0] OFS_STAT  = 12'h020;
  localparam logic [11:0] OFS_CLR   = 12'h024;
  localparam logic [11:0] OFS_EN    = 12'h028;
  localparam logic [11:0] OFS_INFO1 = 12'h02C;
  localparam logic [11:0] OFS_INFO2 = 12'h030;
  localparam logic [11:0] OFS_SET   = 12'h034;
  localparam logic [11:0] OFS_ID    = 12'hFD0;

  localparam int          CTRL_ERR_BIT  = 4;
  localparam int          CTRL_AUTO_BIT = 6;
  localparam int          CTRL_LOCK_BIT = 31;
  localparam logic [31:0] CTRL_RESET    = 32'h0000_0100;
  localparam logic [31:0] CTRL_WMASK    = 32'h8000_0050;
  localparam logic [1:0]  SIZE_WORD     = 2'd2;

  typedef struct packed {
    logic ctrl;
    logic max;
    logic cfg;
    logic idx;
    logic lut;
    logic stat;
    logic clr;
    logic en;
    logic info1;
    logic info2;
    logic set;
    logic id;
  } reg_hit_t;

  function automatic logic [31:0] wrap_index(input logic [31:0] v, input int unsigned n);
    return v % 32'(n);
  endfunction

  function automatic logic [31:0] step_index(input logic [31:0] i, input int unsigned n);
    return (i == 32'(n - 1)) ? 32'd0 : i + 32'd1;
  endfunction

  function automatic logic [31:0] cfg_code(input int unsigned log2_bytes);
    return 32'(log2_bytes) - 32'd5;
  endfunction

  function automatic logic [31:0] merge_ctrl(input logic [31:0] old, input logic [31:0] wd);
    return (old & ~CTRL_WMASK) | (wd & CTRL_WMASK);
  endfunction

  function automatic logic [31:0] id_word(input logic [11:0] ofs);
    return 32'hA0 + 32'(ofs[11:2]);
  endfunction

endpackage

// File: rtl/sec_lut_decode.sv
module sec_lut_decode
  import sec_lut_pkg::*;
(
  input  logic        sel,
  input  logic        write,
  input  logic        secure,
  input  logic [11:0] addr,
  output reg_hit_t    rd_hit,
  output reg_hit_t    wr_hit,
  output logic        ns_block,
  output logic [11:0] id_ofs
);

  reg_hit_t hit;
  logic     allowed;

  always_comb begin
    hit = '0;
    unique case (addr)
      OFS_CTRL:  hit.ctrl  = 1'b1;
      OFS_MAX:   hit.max   = 1'b1;
      OFS_CFG:   hit.cfg   = 1'b1;
      OFS_IDX:   hit.idx   = 1'b1;
      OFS_LUT:   hit.lut   = 1'b1;
      OFS_STAT:  hit.stat  = 1'b1;
      OFS_CLR:   hit.clr   = 1'b1;
      OFS_EN:    hit.en    = 1'b1;
      OFS_INFO1: hit.info1 = 1'b1;
      OFS_INFO2: hit.info2 = 1'b1;
      OFS_SET:   hit.set   = 1'b1;
      default:   hit.id    = (addr >= OFS_ID) && (addr[1:0] == 2'b00);
    endcase
  end

  assign ns_block = sel && !secure && (addr < OFS_ID);
  assign allowed  = sel && !ns_block;
  assign rd_hit   = (allowed && !write) ? hit : '0;
  assign wr_hit   = (allowed && write) ? hit : '0;
  assign id_ofs   = addr - OFS_ID;

endmodule

// File: rtl/sec_lut_table.sv
module sec_lut_table
  import sec_lut_pkg::*;
#(
  parameter int WORDS = 7,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_wr,
  input  logic                 lut_wr,
  input  logic                 step,
  input  logic [31:0]          wdata,
  output logic [IDX_W-1:0]     idx,
  output logic [31:0]          cur_word,
  output logic [WORDS*32-1:0]  flat
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      for (int k = 0; k < WORDS; k++) mem[k] <= '0;
    end else begin
      if (lut_wr) mem[idx] <= wdata;
      if (idx_wr)
        idx <= IDX_W'(wrap_index(wdata, WORDS));
      else if (step)
        idx <= IDX_W'(step_index(32'(idx), WORDS));
    end
  end

  assign cur_word = mem[idx];

  for (genvar k = 0; k < WORDS; k++) begin : g_flat
    assign flat[k*32 +: 32] = mem[k];
  end

endmodule

// File: rtl/sec_lut_irq.sv
module sec_lut_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_wr,
  input  logic        set_wr,
  input  logic        en_wr,
  input  logic        en_bit,
  input  logic        cap_valid,
  input  logic [31:0] cap_addr,
  input  logic [31:0] cap_info,
  output logic        stat,
  output logic        en,
  output logic [31:0] info1,
  output logic [31:0] info2,
  output logic        cap_take,
  output logic        irq
);

  // a clear in the same cycle frees the capture slot for the new event
  assign cap_take = cap_valid && (!stat || clr_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat  <= 1'b0;
      en    <= 1'b1;
      info1 <= '0;
      info2 <= '0;
    end else begin
      stat <= cap_valid || set_wr || (stat && !clr_wr);
      if (en_wr) en <= en_bit;
      if (cap_take) begin
        info1 <= cap_addr;
        info2 <= cap_info;
      end
    end
  end

  assign irq = stat && en;

endmodule

// File: rtl/sec_lut_regbank.sv
module sec_lut_regbank
  import sec_lut_pkg::*;
#(
  parameter int  NUM_BLOCKS  = 200,
  parameter int  BLOCK_BYTES = 128,
  localparam int WORDS       = (NUM_BLOCKS + 31) / 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_write,
  input  logic                bus_secure,
  input  logic [1:0]          bus_size,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                cap_valid,
  input  logic [31:0]         cap_addr,
  input  logic [31:0]         cap_info,
  output logic [WORDS*32-1:0] lut_bits,
  output logic                err_resp_en,
  output logic                lockdown,
  output logic                irq
);

  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int BLK_LOG2 = $clog2(BLOCK_BYTES);

  reg_hit_t          rd_hit, wr_hit;
  logic              ns_block;
  logic [11:0]       id_ofs;
  logic [31:0]       ctrl_q;
  logic [IDX_W-1:0]  tbl_idx;
  logic [31:0]       cur_word;
  logic              stat, en, cap_take;
  logic [31:0]       info1, info2;

  // named events for the checker
  logic ctrl_wr, idx_wr, idx_wr_try, lut_wr, clr_wr, set_wr, autoinc_evt, full_word;

  sec_lut_decode u_dec (
    .sel      (bus_sel),
    .write    (bus_write),
    .secure   (bus_secure),
    .addr     (bus_addr),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .ns_block (ns_block),
    .id_ofs   (id_ofs)
  );

  assign lockdown    = ctrl_q[CTRL_LOCK_BIT];
  assign err_resp_en = ctrl_q[CTRL_ERR_BIT];
  assign full_word   = (bus_size == SIZE_WORD);
  assign ctrl_wr     = wr_hit.ctrl && !lockdown;
  assign idx_wr_try  = wr_hit.idx;
  assign idx_wr      = idx_wr_try && !lockdown;
  assign lut_wr      = wr_hit.lut && !lockdown;
  assign clr_wr      = wr_hit.clr;
  assign set_wr      = wr_hit.set;
  assign autoinc_evt = ctrl_q[CTRL_AUTO_BIT] && full_word && (rd_hit.lut || lut_wr);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= CTRL_RESET;
    else if (ctrl_wr)
      ctrl_q <= merge_ctrl(ctrl_q, bus_wdata);
  end

  sec_lut_table #(.WORDS(WORDS), .IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .lut_wr   (lut_wr),
    .step     (autoinc_evt),
    .wdata    (bus_wdata),
    .idx      (tbl_idx),
    .cur_word (cur_word),
    .flat     (lut_bits)
  );

  sec_lut_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_wr    (clr_wr),
    .set_wr    (set_wr),
    .en_wr     (wr_hit.en),
    .en_bit    (bus_wdata[0]),
    .cap_valid (cap_valid),
    .cap_addr  (cap_addr),
    .cap_info  (cap_info),
    .stat      (stat),
    .en        (en),
    .info1     (info1),
    .info2     (info2),
    .cap_take  (cap_take),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_hit.ctrl)  bus_rdata = ctrl_q;
    if (rd_hit.max)   bus_rdata = 32'(WORDS - 1);
    if (rd_hit.cfg)   bus_rdata = cfg_code(BLK_LOG2);
    if (rd_hit.idx)   bus_rdata = 32'(tbl_idx);
    if (rd_hit.lut)   bus_rdata = cur_word;
    if (rd_hit.stat)  bus_rdata = {31'd0, stat};
    if (rd_hit.en)    bus_rdata = {31'd0, en};
    if (rd_hit.info1) bus_rdata = info1;
    if (rd_hit.info2) bus_rdata = info2;
    if (rd_hit.id)    bus_rdata = id_word(id_ofs);
  end

endmodule

// File: rtl/sec_lut_regbank_chk.sv
module sec_lut_regbank_chk #(
  parameter int WORDS = 7,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_write,
  input logic [31:0]      bus_rdata,
  input logic             ns_block,
  input logic [31:0]      ctrl_q,
  input logic [IDX_W-1:0] tbl_idx,
  input logic             idx_wr_try,
  input logic             autoinc_evt,
  input logic             lockdown,
  input logic             clr_wr,
  input logic             set_wr,
  input logic             cap_valid,
  input logic             cap_take,
  input logic [31:0]      cap_addr,
  input logic [31:0]      info1,
  input logic             stat,
  input logic             en,
  input logic             irq
);

  p_ns_read_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_block && !bus_write) |-> (bus_rdata == 32'd0));

  p_ns_ctrl_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_block && bus_write) |=> $stable(ctrl_q));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tbl_idx) < 32'(WORDS));

  p_autoinc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    autoinc_evt |=> (32'(tbl_idx) ==
      ((32'($past(tbl_idx)) == 32'(WORDS - 1)) ? 32'd0 : 32'($past(tbl_idx)) + 32'd1)));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lockdown |=> lockdown);

  p_lock_idx_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lockdown && idx_wr_try) |=> $stable(tbl_idx));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr && !cap_valid) |=> !stat);

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> stat);

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat && en));

  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take |=> (info1 == $past(cap_addr)));

  p_capture_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && stat && !clr_wr) |=> $stable(info1));

  p_clear_race_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && clr_wr) |=> (stat && info1 == $past(cap_addr)));

endmodule

bind sec_lut_regbank sec_lut_regbank_chk #(.WORDS(WORDS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_write   (bus_write),
  .bus_rdata   (bus_rdata),
  .ns_block    (ns_block),
  .ctrl_q      (ctrl_q),
  .tbl_idx     (tbl_idx),
  .idx_wr_try  (idx_wr_try),
  .autoinc_evt (autoinc_evt),
  .lockdown    (lockdown),
  .clr_wr      (clr_wr),
  .set_wr      (set_wr),
  .cap_valid   (cap_valid),
  .cap_take    (cap_take),
  .cap_addr    (cap_addr),
  .info1       (info1),
  .stat        (stat),
  .en          (en),
  .irq         (irq)
);

// File: tb/sec_lut_regbank_test.sv
module sec_lut_regbank_test;

  localparam int NB = 200;
  localparam int BB = 128;
  localparam int W  = NB / 32 + ((NB % 32) != 0 ? 1 : 0);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_sel = 1'b0, bus_write = 1'b0, bus_secure = 1'b0;
  logic [1:0]     bus_size = 2'd0;
  logic [11:0]    bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           cap_valid = 1'b0;
  logic [31:0]    cap_addr = '0, cap_info = '0;
  logic [W*32-1:0] lut_bits;
  logic           err_resp_en, lockdown, irq;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  live     = 1'b0;

  sec_lut_regbank #(.NUM_BLOCKS(NB), .BLOCK_BYTES(BB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_secure(bus_secure), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_valid(cap_valid),
    .cap_addr(cap_addr), .cap_info(cap_info), .lut_bits(lut_bits),
    .err_resp_en(err_resp_en), .lockdown(lockdown), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_ctrl;
  logic [31:0] m_lut [W];
  int          m_idx;
  bit          m_stat, m_en;
  logic [31:0] m_i1, m_i2;

  function automatic int log2_of(int v);
    int r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  task automatic m_reset();
    m_ctrl = 32'h100; m_idx = 0; m_stat = 0; m_en = 1; m_i1 = 0; m_i2 = 0;
    for (int k = 0; k < W; k++) m_lut[k] = 0;
  endtask

  function automatic logic [31:0] m_read(logic [11:0] a, bit sec);
    if (!sec && a < 12'hFD0) return 32'd0;
    if (a >= 12'hFD0 && a[1:0] == 2'b00) return 32'hA0 + 32'((a - 12'hFD0) / 4);
    case (a)
      12'h000: return m_ctrl;
      12'h010: return 32'(W - 1);
      12'h014: return 32'(log2_of(BB) - 5);
      12'h018: return 32'(m_idx);
      12'h01C: return m_lut[m_idx];
      12'h020: return {31'd0, m_stat};
      12'h028: return {31'd0, m_en};
      12'h02C: return m_i1;
      12'h030: return m_i2;
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_step(bit sel, bit wr, logic [11:0] a, logic [31:0] d, logic [1:0] sz,
                        bit sec, bit cv, logic [31:0] ca, logic [31:0] ci);
    bit acc   = sel && (sec || a >= 12'hFD0);
    bit lk    = m_ctrl[31];
    bit auto  = m_ctrl[6] && sz == 2'd2;
    bit clr   = acc && wr && a == 12'h024;
    bit take  = cv && (!m_stat || clr);
    if (clr) m_stat = 0;
    if (acc && wr && a == 12'h034) m_stat = 1;
    if (cv) m_stat = 1;
    if (take) begin m_i1 = ca; m_i2 = ci; end
    if (acc && wr) begin
      case (a)
        12'h000: if (!lk) m_ctrl = (m_ctrl & ~32'h8000_0050) | (d & 32'h8000_0050);
        12'h018: if (!lk) m_idx = int'(longint'(d) % W);
        12'h01C: if (!lk) begin
                   m_lut[m_idx] = d;
                   if (auto) m_idx = (m_idx + 1) % W;
                 end
        12'h028: m_en = d[0];
        default: ;
      endcase
    end
    if (acc && !wr && a == 12'h01C && auto) m_idx = (m_idx + 1) % W;
  endtask

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // registered outputs compared every cycle
  always @(negedge clk) begin
    if (live) begin
      for (int k = 0; k < W; k++) chk(lut_bits[k*32 +: 32], m_lut[k], "R4 table output");
      chk({31'd0, irq}, {31'd0, m_stat && m_en}, "R10 irq");
      chk({31'd0, err_resp_en}, {31'd0, m_ctrl[4]}, "R7 err_resp_en");
      chk({31'd0, lockdown}, {31'd0, m_ctrl[31]}, "R8 lockdown");
    end
  end

  task automatic op(bit sel, bit wr, logic [11:0] a, logic [31:0] d, logic [1:0] sz,
                    bit sec, bit cv, logic [31:0] ca, logic [31:0] ci, string tag);
    @(negedge clk);
    #2;
    bus_sel = sel; bus_write = wr; bus_addr = a; bus_wdata = d; bus_size = sz;
    bus_secure = sec; cap_valid = cv; cap_addr = ca; cap_info = ci;
    #2;
    if (sel && !wr) chk(bus_rdata, m_read(a, sec), tag);
    @(posedge clk);
    m_step(sel, wr, a, d, sz, sec, cv, ca, ci);
    #1;
    bus_sel = 0; bus_write = 0; cap_valid = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    op(1, 1, a, d, 2'd2, 1, 0, 0, 0, tag);
  endtask
  task automatic rd(logic [11:0] a, string tag);
    op(1, 0, a, 0, 2'd2, 1, 0, 0, 0, tag);
  endtask

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog (all requirements): actual hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    live  = 1;

    // R2 reset values, also compared as literals
    rd(12'h000, "R2 ctrl reset");  chk(m_read(12'h000, 1), 32'h100, "R2 ctrl literal");
    rd(12'h028, "R2 enable reset");
    rd(12'h018, "R2 index reset");
    rd(12'h020, "R2 status reset");
    rd(12'h02C, "R2 addr capture reset");
    rd(12'h030, "R2 info capture reset");
    rd(12'h01C, "R2 table word reset");

    // R3 geometry
    rd(12'h010, "R3 word count"); chk(m_read(12'h010, 1), 32'd6, "R3 literal count");
    rd(12'h014, "R3 block size code"); chk(m_read(12'h014, 1), 32'd2, "R3 literal code");

    // R1 non-secure gating
    op(1, 0, 12'h000, 0, 2'd2, 0, 0, 0, 0, "R1 ns ctrl read");
    op(1, 1, 12'h000, 32'hFFFF_FFFF, 2'd2, 0, 0, 0, 0, "R1 ns ctrl write");
    op(1, 1, 12'h034, 32'h1, 2'd2, 0, 0, 0, 0, "R1 ns set write");
    rd(12'h000, "R1 ctrl after ns write");
    rd(12'h020, "R1 status after ns write");
    op(1, 0, 12'hFD0, 0, 2'd2, 0, 0, 0, 0, "R1 ns id read");
    op(1, 0, 12'hFFC, 0, 2'd2, 1, 0, 0, 0, "R1 s id read");

    // R6 index modulo
    wr(12'h018, 32'd9, "R6 idx write");
    rd(12'h018, "R6 idx 9 mod count");
    wr(12'h018, 32'hFFFF_FFFF, "R6 idx write big");
    rd(12'h018, "R6 idx big mod count");

    // R4 window access
    for (int k = 0; k < W; k++) begin
      wr(12'h018, 32'(k), "R4 idx");
      wr(12'h01C, 32'h1111_0000 + 32'(k * 3), "R4 lut write");
    end
    wr(12'h018, 32'd4, "R4 idx");
    rd(12'h01C, "R4 lut read back");

    // R7 control masking
    wr(12'h000, 32'h0000_7FBF, "R7 ctrl write");
    rd(12'h000, "R7 ctrl masked");
    wr(12'h000, 32'h0000_0050, "R7 ctrl write");
    rd(12'h000, "R7 ctrl err+auto");

    // R5 auto-advance with wrap
    wr(12'h018, 32'd5, "R5 idx");
    wr(12'h01C, 32'hAAAA_0005, "R5 lut write advance");
    wr(12'h01C, 32'hAAAA_0006, "R5 lut write advance");
    rd(12'h018, "R5 idx wrapped");
    rd(12'h01C, "R5 lut read advance");
    op(1, 0, 12'h01C, 0, 2'd1, 1, 0, 0, 0, "R5 half-size read");
    op(1, 1, 12'h01C, 32'h5555_5555, 2'd0, 1, 0, 0, 0, "R5 byte write");
    rd(12'h018, "R5 idx after narrow");

    // R9 / R10 status, enable
    wr(12'h034, 32'h0, "R9 set");
    rd(12'h020, "R9 status set");
    rd(12'h034, "R9 set reads zero");
    wr(12'h028, 32'hFFFF_FFFE, "R9 enable bit0 only");
    rd(12'h028, "R9 enable cleared");
    wr(12'h028, 32'h3, "R9 enable on");
    wr(12'h024, 32'h0, "R9 clear");
    rd(12'h020, "R9 status cleared");
    rd(12'h024, "R9 clear reads zero");

    // R11 capture
    op(0, 0, 0, 0, 0, 1, 1, 32'h1234_5678, 32'h0000_0105, "R11 capture");
    rd(12'h02C, "R11 addr captured");
    rd(12'h030, "R11 info captured");
    op(0, 0, 0, 0, 0, 1, 1, 32'hDEAD_0000, 32'h0000_0001, "R11 second capture");
    rd(12'h02C, "R11 addr held");
    rd(12'h020, "R11 status held");

    // R12 clear racing a capture
    op(1, 1, 12'h024, 0, 2'd2, 1, 1, 32'hCAFE_0040, 32'h0000_0202, "R12 clear+capture");
    rd(12'h020, "R12 status kept");
    rd(12'h02C, "R12 new addr");
    rd(12'h030, "R12 new info");
    wr(12'h024, 32'h0, "R12 clear");

    // R8 lockdown
    wr(12'h018, 32'd2, "R8 idx");
    wr(12'h000, 32'h8000_0040, "R8 lock on");
    rd(12'h000, "R8 ctrl locked");
    wr(12'h01C, 32'hBAD0_BAD0, "R8 dropped lut write");
    rd(12'h018, "R8 idx not advanced");
    wr(12'h018, 32'd0, "R8 dropped idx write");
    wr(12'h000, 32'h0000_0000, "R8 dropped ctrl write");
    rd(12'h000, "R8 ctrl still locked");
    rd(12'h01C, "R8 lut read still advances");
    rd(12'h018, "R8 idx after read");
    wr(12'h028, 32'h0, "R8 enable still writable");
    rd(12'h028, "R8 enable write accepted");

    repeat (2) @(posedge clk);
    @(negedge clk);
    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule